// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM Model

This block is a cycle-accurate, synthesizable model of a synchronous SRAM that lets reads and writes follow each other on every clock with no idle cycle between them. Every command (address, direction, byte selects) is taken on a rising clock edge, but only when the active-low clock enable is low. Read data leaves the array one enabled edge after the command is captured. Write data is taken from the data input two enabled edges after its command. Because of that offset, the data bus slot a write uses is the same slot a read would use, so mixed streams never need a gap.

The 36-bit word is split into four lanes of eight data bits and one parity bit. Each lane has its own byte select. A command can either load a fresh start address or advance a short four-beat burst. The burst runs in a linear or a swapped-bit (interleaved) order, chosen by a static pin. Drive of the data output is decided by internal rules first, and then by an asynchronous active-low output enable. A sleep input parks the block without losing stored data.

The data interface is not a valid/ready stream. Data slots sit at fixed positions in the pipeline. The only form of back-pressure is the clock enable, which freezes every stage together. Callers hold off by raising it and never lose a slot.

Top module: `pipe_sram`

## Requirements
- R1: On a rising edge with cen_n high, nothing is captured and no write is committed. The pipeline, dout and dout_en hold their values, and the edge is not counted toward any latency.
- R2: A load command (adv_ld=0) selects the block only when ce1_n=0, ce2=1 and ce3_n=0 are sampled on the same edge. Any other combination is a deselect: it causes no write, and nothing is driven in its data slot.
- R3: A read captured on enabled edge k puts the word on dout, with dout_en high, after enabled edge k+1. The word stays there until the next enabled edge.
- R4: A write (we_n=0 at capture) takes its data from din at enabled edge k+2. Lane i holds din[8i+7:8i] plus parity din[32+i], and is written only when bw_n[i]=0 at capture. Unselected lanes keep their contents.
- R5: Reads and writes may be issued on consecutive enabled edges in any mix. A read issued right after a write to the same address returns the newly written lanes.
- R6: dout_en is low in the data slot of a write and in the data slot of a deselect, whatever oe_n is.
- R7: oe_n acts asynchronously: while it is high, dout_en is low. dout is all zeros whenever dout_en is low.
- R8: While sleep is high, captured commands act as deselects and dout_en is low. Stored contents are kept.
- R9: With burst_order=0, each adv_ld=1 edge after a selected load continues the burst in the same direction. Chip enables and we_n are ignored on these edges, and byte selects are sampled on each edge. The low two address bits step as (start+n) mod 4, and the upper bits stay fixed.
- R10: With burst_order=1, the low two address bits of beat n are start XOR n.
- R11: adv_ld=1 with no live burst (after reset, a deselect or sleep) is a deselect.
- R12: After reset the pipeline is empty and dout_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, empties the pipeline |
| addr | input | ADDR_W | Word address for load commands |
| we_n | input | 1 | Active-low write command |
| bw_n | input | LANES | Active-low lane write selects |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| cen_n | input | 1 | Active-low clock enable |
| adv_ld | input | 1 | 1 advances the burst, 0 loads a new command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Low-activity request, active high |
| burst_order | input | 1 | 0 linear, 1 interleaved burst order |
| din | input | LANES*(LANE_BITS+1) | Write data bus |
| dout | output | LANES*(LANE_BITS+1) | Read data, zero when not driven |
| dout_en | output | 1 | High when dout is driven |

## Verification
The data path is tried with four kinds of stream. A fill of every address followed by back-to-back reads separates a wrong read latency from a wrong address decode. Alternating writes and reads to one address show whether the same-edge forwarding works, because a missing bypass returns the old word. Partial lane masks with different patterns separate data-lane from parity-bit routing. Streams broken by clock-enable stalls, bad chip-enable patterns, sleep and dead advances show whether a slot is ever dropped or invented. Linear and interleaved bursts from non-aligned starts give different address sequences, so the two orders cannot be mistaken for each other.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  localparam int BURST_BITS = 2;

endpackage

// File: rtl/pipe_sram_cmd.sv
module pipe_sram_cmd #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_ld,
  input  logic              sleep,
  input  logic              burst_order,
  output logic              s1_v,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_bw,
  output logic              s2_v,
  output logic              s2_wr,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_bw
);
  import pipe_sram_pkg::*;

  localparam int BB = BURST_BITS;

  logic              chip_sel;
  logic              live;
  logic              burst_wr;
  logic [ADDR_W-1:0] base;
  logic [BB-1:0]     beat;
  logic [BB-1:0]     beat_nx;
  logic [BB-1:0]     low_nx;
  logic [ADDR_W-1:0] adv_addr;

  assign chip_sel = !ce1_n && ce2 && !ce3_n;
  assign beat_nx  = beat + 1'b1;

  always_comb begin
    if (burst_order_e'(burst_order) == ORDER_INTERLEAVE)
      low_nx = base[BB-1:0] ^ beat_nx;
    else
      low_nx = base[BB-1:0] + beat_nx;
    adv_addr = {base[ADDR_W-1:BB], low_nx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_addr <= '0; s1_bw <= '0;
      s2_v <= 1'b0; s2_wr <= 1'b0; s2_addr <= '0; s2_bw <= '0;
      live <= 1'b0; burst_wr <= 1'b0; base <= '0; beat <= '0;
    end else if (clk_en) begin
      s2_v    <= s1_v;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
      if (sleep) begin
        s1_v <= 1'b0;
        live <= 1'b0;
      end else if (adv_ld) begin
        if (live) begin
          beat    <= beat_nx;
          s1_v    <= 1'b1;
          s1_wr   <= burst_wr;
          s1_addr <= adv_addr;
          s1_bw   <= ~bw_n;
        end else begin
          s1_v <= 1'b0;
        end
      end else if (chip_sel) begin
        base     <= addr;
        beat     <= '0;
        live     <= 1'b1;
        burst_wr <= !we_n;
        s1_v     <= 1'b1;
        s1_wr    <= !we_n;
        s1_addr  <= addr;
        s1_bw    <= ~bw_n;
      end else begin
        s1_v <= 1'b0;
        live <= 1'b0;
      end
    end
  end

  // R2
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !sleep && !adv_ld && !chip_sel |=> !s1_v);

  // R8
  sleep_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && sleep |=> !s1_v);

  // R11
  dead_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv_ld && !live |=> !s1_v);

endmodule

// File: rtl/pipe_sram_store.sv
module pipe_sram_store #(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8
) (
  input  logic                             clk,
  input  logic                             clk_en,
  input  logic                             wr_v,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [LANES-1:0]                 wr_bw,
  input  logic [LANES*(LANE_BITS+1)-1:0]   wr_data,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [LANES*(LANE_BITS+1)-1:0]   rd_word
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAR_LO = LANES * LANE_BITS;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS:0] lane_mem [DEPTH];
    logic [LANE_BITS:0] wr_lane;
    logic [LANE_BITS:0] rd_lane;
    logic               hit;

    assign wr_lane = {wr_data[PAR_LO + g], wr_data[g*LANE_BITS +: LANE_BITS]};
    assign hit     = wr_v && wr_bw[g] && (wr_addr == rd_addr);
    assign rd_lane = hit ? wr_lane : lane_mem[rd_addr];

    always_ff @(posedge clk) begin
      if (clk_en && wr_v && wr_bw[g])
        lane_mem[wr_addr] <= wr_lane;
    end

    assign rd_word[g*LANE_BITS +: LANE_BITS] = rd_lane[LANE_BITS-1:0];
    assign rd_word[PAR_LO + g]               = rd_lane[LANE_BITS];
  end

endmodule

// File: rtl/pipe_sram_out.sv
module pipe_sram_out #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              rd_req,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);
  logic              q_valid;
  logic [WORD_W-1:0] q_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (clk_en) begin
      q_valid <= rd_req;
      if (rd_req) q_data <= rd_word;
    end
  end

  assign dout_en = q_valid && !oe_n && !sleep;
  assign dout    = dout_en ? q_data : '0;

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(q_valid) && $stable(q_data));

  // R3
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && rd_req |=> q_valid);

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram #(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           we_n,
  input  logic [LANES-1:0]               bw_n,
  input  logic                           ce1_n,
  input  logic                           ce2,
  input  logic                           ce3_n,
  input  logic                           cen_n,
  input  logic                           adv_ld,
  input  logic                           oe_n,
  input  logic                           sleep,
  input  logic                           burst_order,
  input  logic [LANES*(LANE_BITS+1)-1:0] din,
  output logic [LANES*(LANE_BITS+1)-1:0] dout,
  output logic                           dout_en
);
  localparam int WORD_W = LANES * (LANE_BITS + 1);

  logic              clk_en;
  logic              s1_v, s1_wr, s2_v, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_bw, s2_bw;
  logic [WORD_W-1:0] rd_word;

  assign clk_en = !cen_n;

  pipe_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr), .we_n(we_n),
    .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv_ld(adv_ld),
    .sleep(sleep), .burst_order(burst_order),
    .s1_v(s1_v), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_bw(s1_bw),
    .s2_v(s2_v), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_bw(s2_bw)
  );

  pipe_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_store (
    .clk(clk), .clk_en(clk_en), .wr_v(s2_v && s2_wr), .wr_addr(s2_addr),
    .wr_bw(s2_bw), .wr_data(din), .rd_addr(s1_addr), .rd_word(rd_word)
  );

  pipe_sram_out #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rd_req(s1_v && !s1_wr),
    .rd_word(rd_word), .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  // R6
  wr_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v && s2_wr |-> !dout_en);

  // R12
  empty_after_rst_chk: assert property (@(posedge clk)
    !rst_n |=> !dout_en);

endmodule

// File: tb/pipe_sram_bench.sv
module pipe_sram_bench;
  localparam int AW = 6;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic          cen_n = 1'b0, adv_ld = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic          burst_order = 1'b0;
  logic [WW-1:0] din = '0;
  logic [WW-1:0] dout;
  logic          dout_en;

  pipe_sram u_pipe_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we_n(we_n), .bw_n(bw_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .cen_n(cen_n), .adv_ld(adv_ld),
    .oe_n(oe_n), .sleep(sleep), .burst_order(burst_order), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R12";

  logic [WW-1:0] ref_mem [64];
  logic          p1_v = 0, p1_wr = 0, p2_v = 0, p2_wr = 0;
  logic [AW-1:0] p1_a = '0, p2_a = '0;
  logic [3:0]    p1_bw = '0, p2_bw = '0;
  logic [WW-1:0] p1_d = '0, p2_d = '0, p2_exp = '0;

  task automatic check(input bit ok, input string what, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // kind: 0 deselect, 1 read, 2 write, 3 advance (read burst), 4 advance (write burst), 5 advance with no burst
  task automatic step(input int kind, input logic [AW-1:0] a, input logic [3:0] bw,
                      input bit stall = 0, input bit oe_off = 0, input bit slp = 0,
                      input logic [2:0] cebad = 3'b000);
    logic          exp_en;
    logic [63:0]   rnd;
    logic [WW-1:0] wd;
    bit            v;
    exp_en = p2_v && !p2_wr && !oe_n && !sleep;
    check(dout_en === exp_en, "dout_en", {35'd0, dout_en}, {35'd0, exp_en});
    if (exp_en) check(dout === p2_exp, "read word", dout, p2_exp);
    else        check(dout === '0, "idle data", dout, '0);
    rnd    = {$urandom(), $urandom()};
    wd     = rnd[WW-1:0];
    rnd    = {$urandom(), $urandom()};
    cen_n  = stall;
    oe_n   = oe_off;
    sleep  = slp;
    bw_n   = ~bw;
    adv_ld = (kind >= 3);
    addr   = (kind >= 3) ? rnd[AW-1:0] : a;
    we_n   = (kind == 2) ? 1'b0 : (kind == 1) ? 1'b1 : rnd[40];
    ce1_n  = (kind == 0) || (kind >= 3) || cebad[0];
    ce2    = !cebad[1];
    ce3_n  = cebad[2];
    din    = (p2_v && p2_wr) ? p2_d : rnd[WW+8-1:8];
    v      = (((kind == 1 || kind == 2) && cebad == 3'b000) || kind == 3 || kind == 4) && !slp;
    @(posedge clk);
    if (!stall) begin
      if (p2_v && p2_wr)
        for (int i = 0; i < 4; i++)
          if (p2_bw[i]) begin
            ref_mem[p2_a][i*8 +: 8] = p2_d[i*8 +: 8];
            ref_mem[p2_a][32+i]     = p2_d[32+i];
          end
      p2_v = p1_v; p2_wr = p1_wr; p2_a = p1_a; p2_bw = p1_bw; p2_d = p1_d;
      if (p2_v && !p2_wr) p2_exp = ref_mem[p2_a];
      p1_v = v; p1_wr = (kind == 2 || kind == 4); p1_a = a; p1_bw = bw; p1_d = wd;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(0, '0, 4'h0);
  endtask

  task automatic t_reset();
    tag = "R12";
    check(dout_en === 1'b0, "dout_en after reset", {35'd0, dout_en}, '0);
    step(0, '0, 4'h0);
  endtask

  task automatic t_fill_read();
    tag = "R4";
    for (int i = 0; i < 64; i++) step(2, AW'(i), 4'hF);
    tag = "R3";
    for (int i = 63; i >= 0; i--) step(1, AW'(i), 4'h0);
    drain();
  endtask

  task automatic t_mix();
    tag = "R5";
    for (int i = 0; i < 6; i++) begin
      step(2, 6'h05, 4'hF);
      step(1, 6'h05, 4'h0);
      step(2, AW'(20 + i), 4'hF);
      step(1, 6'h05, 4'h0);
    end
    tag = "R6";
    step(1, 6'h07, 4'h0, 0, 0);
    step(2, 6'h07, 4'hF, 0, 0);
    step(1, 6'h07, 4'h0, 0, 0);
    drain();
  endtask

  task automatic t_lanes();
    tag = "R4";
    step(2, 6'h10, 4'b0001);
    step(2, 6'h11, 4'b1010);
    step(2, 6'h12, 4'b0100);
    step(2, 6'h13, 4'b0000);
    step(2, 6'h14, 4'b1000);
    step(1, 6'h10, 4'h0);
    step(1, 6'h11, 4'h0);
    step(1, 6'h12, 4'h0);
    step(1, 6'h13, 4'h0);
    step(1, 6'h14, 4'h0);
    drain();
  endtask

  task automatic t_stall();
    tag = "R1";
    step(2, 6'h20, 4'hF);
    step(2, 6'h21, 4'hF, 1);
    step(1, 6'h22, 4'hF, 1);
    step(1, 6'h20, 4'h0);
    step(2, 6'h23, 4'h5, 1);
    step(1, 6'h21, 4'h0);
    step(2, 6'h24, 4'hF, 1);
    step(2, 6'h25, 4'hF, 1);
    step(2, 6'h26, 4'hF, 1);
    step(1, 6'h20, 4'h0);
    step(0, '0, 4'h0, 1);
    drain();
  endtask

  task automatic t_select();
    tag = "R2";
    step(2, 6'h30, 4'hF, 0, 0, 0, 3'b001);
    step(2, 6'h30, 4'hF, 0, 0, 0, 3'b010);
    step(2, 6'h30, 4'hF, 0, 0, 0, 3'b100);
    step(1, 6'h30, 4'h0, 0, 0, 0, 3'b010);
    step(1, 6'h30, 4'h0);
    step(0, '0, 4'h0);
    step(1, 6'h31, 4'h0);
    drain();
  endtask

  task automatic t_oe();
    tag = "R7";
    step(1, 6'h02, 4'h0);
    step(1, 6'h03, 4'h0);
    step(1, 6'h04, 4'h0, 0, 1);
    step(0, '0, 4'h0, 0, 1);
    step(0, '0, 4'h0, 0, 0);
    drain();
  endtask

  task automatic t_sleep();
    tag = "R8";
    step(1, 6'h08, 4'h0);
    step(2, 6'h08, 4'hF, 0, 0, 1);
    step(1, 6'h09, 4'h0, 0, 0, 1);
    step(0, '0, 4'h0, 0, 0, 1);
    step(0, '0, 4'h0, 0, 0, 1);
    step(1, 6'h08, 4'h0);
    drain();
  endtask

  task automatic t_burst_linear();
    tag = "R9";
    burst_order = 1'b0;
    step(2, 6'h0A, 4'hF);
    step(4, 6'h0B, 4'h3);
    step(4, 6'h08, 4'hF);
    step(4, 6'h09, 4'hC);
    step(1, 6'h0A, 4'h0);
    step(3, 6'h0B, 4'h0);
    step(3, 6'h08, 4'h0);
    step(3, 6'h09, 4'h0);
    drain();
  endtask

  task automatic t_burst_interleave();
    tag = "R10";
    burst_order = 1'b1;
    step(0, '0, 4'h0);
    step(2, 6'h11, 4'hF);
    step(4, 6'h10, 4'hF);
    step(4, 6'h13, 4'hF);
    step(4, 6'h12, 4'hF);
    step(1, 6'h11, 4'h0);
    step(3, 6'h10, 4'h0);
    step(3, 6'h13, 4'h0);
    step(3, 6'h12, 4'h0);
    drain();
    burst_order = 1'b0;
    step(0, '0, 4'h0);
  endtask

  task automatic t_dead_adv();
    tag = "R11";
    step(0, '0, 4'h0);
    step(5, '0, 4'hF);
    step(5, '0, 4'hF);
    step(0, '0, 4'h0, 0, 0, 1);
    step(5, '0, 4'hF);
    drain();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_read();
    t_mix();
    t_lanes();
    t_stall();
    t_select();
    t_oe();
    t_sleep();
    t_burst_linear();
    t_burst_interleave();
    t_dead_adv();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule